// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from eight devices and one edge-triggered non-maskable input. It gives the processor two request lines and one vector number. The maskable line is the result of a priority arbitration. Each device input has a three-bit priority level. A global enable gates the maskable line. In-service tracking stops a request of equal or lower level from interrupting a handler that is running. A device at a strictly higher level can still preempt that handler and nest inside it.

The processor pulses an acknowledge strobe to take the current request. The controller then latches a vector number, which stays valid until the next acknowledge that takes effect. The non-maskable event gets vector 2, because vectors 0 to 31 are kept for non-maskable and error events. A device with index i gets vector 32 + i. An end-of-service strobe retires the highest-level handler that is in service, and that lets lower levels request again. Device inputs are level-sensitive. A source that is still asserted after its handler retires requests again.

Top module: `vec_irq_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, `nmi_req` and `irq_req` are 0, `vec_out` is 0 and nothing is in service.
- R2: A rising edge on `nmi_in` sets `nmi_req` at the next clock edge. `nmi_req` stays 1 until an acknowledge. An input that is held high after that acknowledge does not raise `nmi_req` again.
- R3: An acknowledge while `nmi_req` is 1 latches vector 2 and clears `nmi_req`. This happens whatever the state of `irq_enable` or of the in-service set, and it leaves the in-service set unchanged.
- R4: `irq_req` rises one clock after a device input is asserted, provided `irq_enable` is 1 and no handler is in service. While `irq_enable` is 0, `irq_req` is 0. The request is not lost and reappears when the enable returns.
- R5: Among the requesting devices that are not in service, the highest level wins. When levels are equal, the lower index wins. The vector of device i is 32 + i.
- R6: An acknowledge that takes a device request latches that device's vector, and `vec_out` then holds this value until the next acknowledge that takes effect. An acknowledge while neither line is requesting leaves `vec_out` unchanged.
- R7: While a handler is in service, `irq_req` is 1 only for a requester whose level is strictly higher than the highest in-service level. Such a request preempts, and its acknowledge nests a second in-service entry.
- R8: An end-of-service strobe retires only the highest-level in-service entry. A nested lower-level entry keeps blocking requests at its own level and below.
- R9: A device input that is still asserted when its entry retires requests again. A device input that has been deasserted no longer requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 8 | Level-sensitive device requests, bit i is device i |
| src_lvl | input | 24 | Device levels, bits [3i+2:3i] are device i's level, 7 is highest |
| irq_enable | input | 1 | Global enable of the maskable line |
| nmi_in | input | 1 | Non-maskable input, rising-edge triggered |
| ack | input | 1 | Acknowledge strobe from the processor |
| eoi | input | 1 | End-of-service strobe |
| nmi_req | output | 1 | Non-maskable request to the processor |
| irq_req | output | 1 | Maskable request to the processor |
| vec_out | output | 8 | Vector latched by the last acknowledge that took effect |

## Verification
The bench sweeps every pair of devices under several level patterns that include ties. A design that resolves a tie toward the higher index, or lets an equal level preempt, then reports a wrong vector or a false `irq_req`. Nested service is exercised by retiring entries one at a time. A design that clears the wrong in-service entry, or all of them, would let the lower device request while it should still be blocked. The non-maskable path is tested with the input held high across an acknowledge, to catch a level-triggered implementation. It is also acknowledged while a device is requesting, to catch an acknowledge that corrupts the in-service set. Acknowledges made while nothing is requesting confirm that the latched vector does not move.

// File: rtl/vic_pkg.sv
package vic_pkg;

    parameter int unsigned SRC_N     = 8;
    parameter int unsigned PRIO_W    = 3;
    parameter int unsigned VEC_W     = 8;
    parameter int unsigned MVEC_BASE = 32;
    parameter int unsigned NMI_VEC   = 2;

    localparam int unsigned IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;
    localparam int unsigned LVL_W = SRC_N * PRIO_W;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] lvl;
    } pick_t;

    typedef enum logic [1:0] {
        GRANT_NONE = 2'd0,
        GRANT_NMI  = 2'd1,
        GRANT_DEV  = 2'd2
    } grant_e;

    // Highest level among set bits; equal levels resolve to the lowest index
    function automatic pick_t pick_top(input logic [SRC_N-1:0] cand,
                                       input logic [LVL_W-1:0] lvls);
        pick_t r;
        r = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (cand[i] && (!r.hit || lvls[i*PRIO_W +: PRIO_W] >= r.lvl)) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
                r.lvl = lvls[i*PRIO_W +: PRIO_W];
            end
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] dev_vector(input logic [IDX_W-1:0] idx);
        return VEC_W'(MVEC_BASE) + VEC_W'(idx);
    endfunction

endpackage

// File: rtl/vic_nmi_edge.sv
module vic_nmi_edge
    import vic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic take,
    output logic pend
);

    logic nmi_q;
    logic rise;

    assign rise = nmi_in & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            // a fresh edge in the same cycle as an acknowledge is kept
            if (rise)
                pend <= 1'b1;
            else if (take)
                pend <= 1'b0;
        end
    end

    AST_NMI_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_in) |=> pend); // R2

    AST_NMI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend && !take) |=> pend); // R2

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] isr,
    input  logic [LVL_W-1:0] lvls,
    input  pick_t            isr_top,
    input  logic             enable,
    output pick_t            pick,
    output logic             irq_req
);

    logic [SRC_N-1:0] cand;

    genvar g;
    generate
        for (g = 0; g < SRC_N; g++) begin : g_cand
            assign cand[g] = pend[g] & ~isr[g];
        end
    endgenerate

    logic beats_isr;

    always_comb begin
        pick      = pick_top(cand, lvls);
        beats_isr = !isr_top.hit || (pick.lvl > isr_top.lvl);
        irq_req   = enable && pick.hit && beats_isr;
    end

    always_comb begin
        AST_NO_REQ_WHILE_OFF: assert (!( !enable && irq_req )); // R4
    end

endmodule

// File: rtl/vic_service.sv
module vic_service
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  logic             eoi,
    input  logic             nmi_pend,
    input  logic             irq_req,
    input  pick_t            pick,
    input  logic [LVL_W-1:0] lvls,
    output logic [SRC_N-1:0] isr,
    output pick_t            isr_top,
    output logic             nmi_take,
    output logic [VEC_W-1:0] vec
);

    grant_e           grant;
    logic [SRC_N-1:0] clr_mask;
    logic [SRC_N-1:0] set_mask;

    always_comb begin
        isr_top = pick_top(isr, lvls);
        if (!ack)
            grant = GRANT_NONE;
        else if (nmi_pend)
            grant = GRANT_NMI;
        else if (irq_req)
            grant = GRANT_DEV;
        else
            grant = GRANT_NONE;
        nmi_take = (grant == GRANT_NMI);
    end

    genvar g;
    generate
        for (g = 0; g < SRC_N; g++) begin : g_mask
            assign clr_mask[g] = eoi && isr_top.hit && (isr_top.idx == IDX_W'(g));
            assign set_mask[g] = (grant == GRANT_DEV) && (pick.idx == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            isr <= '0;
            vec <= '0;
        end else begin
            isr <= (isr & ~clr_mask) | set_mask;
            case (grant)
                GRANT_NMI: vec <= VEC_W'(NMI_VEC);
                GRANT_DEV: vec <= dev_vector(pick.idx);
                default:   vec <= vec;
            endcase
        end
    end

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
        (grant == GRANT_NONE) |=> $stable(vec)); // R6

    AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (rst)
        nmi_take |=> (vec == VEC_W'(NMI_VEC)) && $stable(isr)); // R3

    AST_DEV_VECTOR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (grant == GRANT_DEV) |=> (vec >= VEC_W'(MVEC_BASE))); // R5

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi && grant == GRANT_NONE && isr != '0)
        |=> ($countones(isr) == $countones($past(isr)) - 1)); // R8

    AST_ACK_NESTS: assert property (@(posedge clk) disable iff (rst)
        (grant == GRANT_DEV && !eoi)
        |=> ($countones(isr) == $countones($past(isr)) + 1)); // R7

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_req,
    input  logic [LVL_W-1:0] src_lvl,
    input  logic             irq_enable,
    input  logic             nmi_in,
    input  logic             ack,
    input  logic             eoi,
    output logic             nmi_req,
    output logic             irq_req,
    output logic [VEC_W-1:0] vec_out
);

    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] isr;
    pick_t            pick;
    pick_t            isr_top;
    logic             nmi_pend;
    logic             nmi_take;

    // level inputs are registered once before arbitration
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= src_req;
    end

    vic_nmi_edge u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_in (nmi_in),
        .take   (nmi_take),
        .pend   (nmi_pend)
    );

    vic_arbiter u_arb (
        .pend    (pend_q),
        .isr     (isr),
        .lvls    (src_lvl),
        .isr_top (isr_top),
        .enable  (irq_enable),
        .pick    (pick),
        .irq_req (irq_req)
    );

    vic_service u_svc (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .eoi      (eoi),
        .nmi_pend (nmi_pend),
        .irq_req  (irq_req),
        .pick     (pick),
        .lvls     (src_lvl),
        .isr      (isr),
        .isr_top  (isr_top),
        .nmi_take (nmi_take),
        .vec      (vec_out)
    );

    assign nmi_req = nmi_pend;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!nmi_req && vec_out == '0 && isr == '0)); // R1

    AST_NO_SELF_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (irq_req && isr != '0) |-> (pick.lvl > isr_top.lvl) && !isr[pick.idx]); // R7

endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;

    localparam int N = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  src_req;
    logic [N*PW-1:0] src_lvl;
    logic          irq_enable;
    logic          nmi_in;
    logic          ack;
    logic          eoi;
    logic          nmi_req;
    logic          irq_req;
    logic [7:0]    vec_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int lv [N];

    always #4 clk = ~clk;

    vec_irq_ctrl u_vec_irq_ctrl (
        .clk(clk), .rst(rst), .src_req(src_req), .src_lvl(src_lvl),
        .irq_enable(irq_enable), .nmi_in(nmi_in), .ack(ack), .eoi(eoi),
        .nmi_req(nmi_req), .irq_req(irq_req), .vec_out(vec_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_levels(input int s);
        for (int k = 0; k < N; k++) begin
            lv[k] = (k * (s + 1) + s) % 8;
            src_lvl[k*PW +: PW] = PW'(lv[k]);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; step(); eoi = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_req = '0; src_lvl = '0; irq_enable = 1'b1;
        nmi_in = 1'b0; ack = 1'b0; eoi = 1'b0;
        repeat (3) step();
        chk(nmi_req == 0 && irq_req == 0, "R1 reqs low in reset", {nmi_req, irq_req}, 0);
        chk(vec_out == 0, "R1 vector zero in reset", vec_out, 0);
        rst = 1'b0;
        step();
        chk(nmi_req == 0 && irq_req == 0 && vec_out == 0, "R1 idle after reset",
            {nmi_req, irq_req, vec_out}, 0);

        // R6: acknowledge with nothing requesting leaves vector alone
        do_ack();
        chk(vec_out == 0, "R6 idle ack", vec_out, 0);

        // R2 / R3: non-maskable edge behaviour
        nmi_in = 1'b1; step();
        chk(nmi_req == 1, "R2 nmi edge latched", nmi_req, 1);
        step(); step();
        chk(nmi_req == 1, "R2 nmi held until ack", nmi_req, 1);
        do_ack();
        chk(vec_out == 2, "R3 nmi vector", vec_out, 2);
        chk(nmi_req == 0, "R3 nmi cleared by ack", nmi_req, 0);
        step(); step();
        chk(nmi_req == 0, "R2 held level does not retrigger", nmi_req, 0);
        nmi_in = 1'b0; step();

        // R3 with a device requesting and mask closed
        set_levels(0);
        src_req = 8'b0000_1000; step();
        chk(irq_req == 1, "R4 device request", irq_req, 1);
        irq_enable = 1'b0;
        nmi_in = 1'b1; step();
        chk(irq_req == 0, "R4 disabled line low", irq_req, 0);
        chk(nmi_req == 1, "R3 nmi ignores enable", nmi_req, 1);
        do_ack();
        chk(vec_out == 2, "R3 nmi wins while disabled", vec_out, 2);
        do_ack();
        chk(vec_out == 2, "R6 masked ack leaves vector", vec_out, 2);
        irq_enable = 1'b1; step();
        chk(irq_req == 1, "R4 request kept while disabled", irq_req, 1);
        do_ack();
        chk(vec_out == 35, "R3 device set untouched by nmi ack", vec_out, 35);
        chk(irq_req == 0, "R7 in-service source blocked", irq_req, 0);
        // nmi while a device is in service
        nmi_in = 1'b0; step(); nmi_in = 1'b1; step();
        do_ack();
        chk(vec_out == 2, "R3 nmi over in-service", vec_out, 2);
        nmi_in = 1'b0;
        do_eoi();
        chk(irq_req == 1, "R9 still asserted re-requests", irq_req, 1);
        src_req = '0; step();
        chk(irq_req == 0, "R9 dropped source idle", irq_req, 0);

        // R5: pair sweep with tie patterns
        for (int s = 0; s < 8; s++) begin
            set_levels(s);
            for (int a = 0; a < N; a++) begin
                for (int b = a + 1; b < N; b++) begin
                    int w;
                    w = (lv[b] > lv[a]) ? b : a;
                    src_req = '0; src_req[a] = 1'b1; src_req[b] = 1'b1;
                    step();
                    chk(irq_req == 1, "R4 pair request", irq_req, 1);
                    do_ack();
                    chk(vec_out == 32 + w, "R5 pair winner", vec_out, 32 + w);
                    src_req = '0;
                    do_eoi();
                    chk(irq_req == 0, "R9 pair cleared", irq_req, 0);
                end
            end
            // all eight at once
            begin
                int w;
                w = 0;
                for (int k = 1; k < N; k++) if (lv[k] > lv[w]) w = k;
                src_req = '1; step();
                do_ack();
                chk(vec_out == 32 + w, "R5 all-source winner", vec_out, 32 + w);
                src_req = '0;
                do_eoi();
            end
        end

        // R7 / R8: preemption and nested retirement
        for (int s = 0; s < 4; s++) begin
            set_levels(s);
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    bit pre;
                    if (a == b) continue;
                    pre = (lv[b] > lv[a]);
                    src_req = '0; src_req[a] = 1'b1; step();
                    do_ack();
                    chk(vec_out == 32 + a, "R6 first vector", vec_out, 32 + a);
                    src_req[b] = 1'b1; step();
                    chk(irq_req == pre, "R7 preempt decision", irq_req, pre);
                    if (pre) begin
                        do_ack();
                        chk(vec_out == 32 + b, "R7 nested vector", vec_out, 32 + b);
                        src_req[b] = 1'b0;
                        do_eoi();
                        chk(irq_req == 0, "R8 lower entry still blocks", irq_req, 0);
                        do_eoi();
                        chk(irq_req == 1, "R9 lower source re-requests", irq_req, 1);
                    end else begin
                        do_ack();
                        chk(vec_out == 32 + a, "R6 blocked ack keeps vector", vec_out, 32 + a);
                        do_eoi();
                        chk(irq_req == 1, "R8 retire unblocks", irq_req, 1);
                    end
                    src_req = '0; step();
                    chk(irq_req == 0, "R9 released", irq_req, 0);
                end
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule